// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block decides, for every output clock of a clock generator, whether that clock may toggle. It does not make clocks. It takes an already running CPU-domain clock and PCI-domain clock. From them it drives gated copies, together with the per-output gate enables behind them. An enable changes only on the falling edge of its own clock, so a gated output never shows a shortened high pulse.

Four things can hold an output low. A power-down request that is seen low on two consecutive CPU-clock samples stops everything. A CPU stop request stops the CPU outputs, except those whose free-run bit is set. A PCI stop request stops every PCI output except the free-running one at index 0. A per-output enable bit of 0 holds its output low at all times. When power-down ends, a relock counter of programmable length must expire before the outputs run again. At power-up the block also captures a 5-bit frequency strap code when the active-low power-good input is first seen asserted. It keeps all outputs off until that capture has happened, and it reports the captured code with the live multiplier-select input.

Top module: `clkstop_ctrl`

## Requirements
- R1: A low on `pd_n` that is seen at only one CPU-clock rising edge causes no change. Power-down is entered only after `pd_n` has been sampled low at two consecutive edges.
- R2: Once power-down is entered, every gate enable goes to 0 and every gated output stays low.
- R3: While `cpu_stop_n` is low, each CPU output whose `cpu_free` bit is 0 is gated off.
- R4: A CPU output whose `cpu_free` bit is 1 keeps running while `cpu_stop_n` is low.
- R5: While `pci_stop_n` is low, PCI outputs 1 and up are gated off. PCI output 0 keeps running.
- R6: An enable bit of 0 in `cpu_en` or `pci_en` holds that output off, whatever the stop inputs and free-run bits are.
- R7: The strap code is captured at the first CPU-clock cycle in which the synchronized `pwr_good_n` is low. `strap_rb` = {captured code[4:0], mult_sel}. Later changes on `strap_fs` or `pwr_good_n` leave the captured code unchanged.
- R8: Until the strap code has been captured, all gate enables are 0.
- R9: `pd_n` is driven high just after CPU edge k. The CPU gate enables are then still 0 after edge k+L+3, where L = `relock_len`, and become 1 after edge k+L+4, from its falling edge on.
- R10: During reset all gate enables and gated outputs are 0, and the strap field of `strap_rb` reads 0.
- R11: Every high pulse on a gated output lasts a full half period of its source clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu | input | 1 | CPU-domain source clock; the control logic runs on it |
| clk_pci | input | 1 | PCI-domain source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_n | input | 1 | Active-low power-good strobe that qualifies strap capture |
| strap_fs | input | 5 | Frequency-select strap code |
| mult_sel | input | 1 | Multiplier-select level, reported in the readback |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_n | input | 1 | Active-low stop request for CPU outputs |
| pci_stop_n | input | 1 | Active-low stop request for PCI outputs |
| cpu_en | input | 3 | Per-output enable for CPU outputs |
| pci_en | input | 7 | Per-output enable for PCI outputs |
| cpu_free | input | 3 | Per-output free-run bits for CPU outputs |
| relock_len | input | 16 | Relock wait length in CPU cycles |
| cpu_clk_out | output | 3 | Gated CPU clocks |
| pci_clk_out | output | 7 | Gated PCI clocks |
| cpu_gate | output | 3 | CPU gate enables |
| pci_gate | output | 7 | PCI gate enables |
| strap_rb | output | 6 | Readback: {captured strap code, mult_sel} |

## Verification
Some behaviours are checked by the assertions on every CPU clock:
- power-down is entered only after two low `pd_n` samples;
- CPU enables are off during power-down and while the straps are pending;
- CPU outputs that are not free-running are off under a CPU stop;
- the captured strap code is held once taken.

Other behaviours only the directed scenarios can show:
- the exact relock release edge for zero and non-zero lengths;
- the PCI-domain outcomes that pass through the synchronizer;
- the per-output enable overriding the free-run bits;
- that no runt pulse appears while the enables are switching.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_DOWN   = 2'd1,
    PS_RELOCK = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/clkstop_rst_sync.sv
module clkstop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate_cell.sv
module clkstop_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic en,
  output logic gclk
);
  logic req_s;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign req_s = req;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], req};
      end
      assign req_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // enable is only updated on the falling edge, while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= req_s;
  end

  assign gclk = clk & en;
endmodule

// File: rtl/clkstop_pwr_ctrl.sv
module clkstop_pwr_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_CPU = 3,
  parameter int N_PCI = 7,
  parameter int FS_W  = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_good_n,
  input  logic [FS_W-1:0]  strap_fs,
  input  logic [CNT_W-1:0] relock_len,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic [N_CPU-1:0] cpu_free,
  input  logic [N_PCI-1:0] pci_en,
  output logic [N_CPU-1:0] cpu_req,
  output logic [N_PCI-1:0] pci_req,
  output logic [FS_W-1:0]  strap_q,
  output logic             strap_done,
  output logic             in_down,
  output logic             cpu_run_q
);
  logic [1:0] pd_s, cs_s, ps_s, pg_s;
  pwr_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FS_W-1:0]  strap_d;
  logic             done_d, cnt_en, strap_en;
  logic             pd_low2, pd_high2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_s <= 2'b11;
      cs_s <= 2'b11;
      ps_s <= 2'b11;
      pg_s <= 2'b11;
    end else begin
      pd_s <= {pd_s[0], pd_n};
      cs_s <= {cs_s[0], cpu_stop_n};
      ps_s <= {ps_s[0], pci_stop_n};
      pg_s <= {pg_s[0], pwr_good_n};
    end
  end

  assign pd_low2  = (pd_s == 2'b00);
  assign pd_high2 = (pd_s == 2'b11);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      PS_RUN: if (pd_low2) state_d = PS_DOWN;
      PS_DOWN: if (pd_high2) begin
        state_d = PS_RELOCK;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      PS_RELOCK: begin
        if (pd_low2) state_d = PS_DOWN;
        else if (cnt_q == relock_len) state_d = PS_RUN;
        else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = PS_DOWN;
    endcase
  end

  assign strap_en = !strap_done && !pg_s[1];
  assign strap_d  = strap_fs;
  assign done_d   = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_RUN;
      cnt_q      <= '0;
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (strap_en) begin
        strap_q    <= strap_d;
        strap_done <= done_d;
      end
    end
  end

  logic live;
  assign live      = strap_done && (state_q == PS_RUN);
  assign in_down   = (state_q == PS_DOWN);
  assign cpu_run_q = cs_s[1];

  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_req
      assign cpu_req[i] = live && cpu_en[i] && (cs_s[1] || cpu_free[i]);
    end
    for (genvar j = 0; j < N_PCI; j++) begin : g_pci_req
      if (j == 0) begin : g_free
        assign pci_req[j] = live && pci_en[j];
      end else begin : g_stoppable
        assign pci_req[j] = live && pci_en[j] && ps_s[1];
      end
    end
  endgenerate

  // R1: entry into power-down needs two consecutive low samples of pd_n
  p_pd_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_down) |-> (!$past(pd_n, 2) && !$past(pd_n, 3)));

  // R7: a captured strap code never changes afterwards
  p_strap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(strap_q));
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int N_CPU      = 3,
  parameter int N_PCI      = 7,
  parameter int FS_W       = 5,
  parameter int CNT_W      = 16,
  parameter int PCI_SYNC   = 2,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_cpu,
  input  logic             clk_pci,
  input  logic             rst_n,
  input  logic             pwr_good_n,
  input  logic [FS_W-1:0]  strap_fs,
  input  logic             mult_sel,
  input  logic             pd_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic [N_PCI-1:0] pci_en,
  input  logic [N_CPU-1:0] cpu_free,
  input  logic [CNT_W-1:0] relock_len,
  output logic [N_CPU-1:0] cpu_clk_out,
  output logic [N_PCI-1:0] pci_clk_out,
  output logic [N_CPU-1:0] cpu_gate,
  output logic [N_PCI-1:0] pci_gate,
  output logic [FS_W:0]    strap_rb
);
  localparam int RB_W = FS_W + 1;

  logic rst_cpu_n, rst_pci_n;
  logic [N_CPU-1:0] cpu_req;
  logic [N_PCI-1:0] pci_req;
  logic [FS_W-1:0]  strap_q;
  logic strap_done, in_down, cpu_run_q;

  clkstop_rst_sync #(.STAGES(RST_STAGES)) u_rst_cpu (
    .clk(clk_cpu), .rst_n(rst_n), .rst_sync_n(rst_cpu_n));
  clkstop_rst_sync #(.STAGES(RST_STAGES)) u_rst_pci (
    .clk(clk_pci), .rst_n(rst_n), .rst_sync_n(rst_pci_n));

  clkstop_pwr_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .FS_W(FS_W), .CNT_W(CNT_W)) u_pwr (
    .clk(clk_cpu), .rst_n(rst_cpu_n), .pd_n(pd_n), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .pwr_good_n(pwr_good_n), .strap_fs(strap_fs),
    .relock_len(relock_len), .cpu_en(cpu_en), .cpu_free(cpu_free), .pci_en(pci_en),
    .cpu_req(cpu_req), .pci_req(pci_req), .strap_q(strap_q),
    .strap_done(strap_done), .in_down(in_down), .cpu_run_q(cpu_run_q));

  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_cell
      clkstop_gate_cell #(.SYNC_STAGES(0)) u_cell (
        .clk(clk_cpu), .rst_n(rst_cpu_n), .req(cpu_req[i]),
        .en(cpu_gate[i]), .gclk(cpu_clk_out[i]));
    end
    for (genvar j = 0; j < N_PCI; j++) begin : g_pci_cell
      clkstop_gate_cell #(.SYNC_STAGES(PCI_SYNC)) u_cell (
        .clk(clk_pci), .rst_n(rst_pci_n), .req(pci_req[j]),
        .en(pci_gate[j]), .gclk(pci_clk_out[j]));
    end
  endgenerate

  assign strap_rb = RB_W'({strap_q, mult_sel});

  // R2: CPU enables are off while power-down persists
  p_down_cpu_off_r2: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    (in_down && $past(in_down)) |-> (cpu_gate == '0));

  // R8: nothing runs until the straps are captured
  p_no_out_before_strap_r8: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    !strap_done |-> (cpu_gate == '0 && pci_gate == '0));

  // R3: under a CPU stop only free-running CPU outputs may be enabled
  p_cpu_stop_r3: assert property (@(posedge clk_cpu) disable iff (!rst_cpu_n)
    (!cpu_run_q && $stable(cpu_free)) |-> ((cpu_gate & ~cpu_free) == '0));
endmodule

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;
  logic clk_cpu = 1'b0, clk_pci = 1'b0, rst_n;
  logic pwr_good_n, mult_sel, pd_n, cpu_stop_n, pci_stop_n;
  logic [4:0]  strap_fs;
  logic [2:0]  cpu_en, cpu_free, cpu_gate, cpu_clk_out;
  logic [6:0]  pci_en, pci_gate, pci_clk_out;
  logic [15:0] relock_len;
  logic [5:0]  strap_rb;
  int n_checks = 0, n_fail = 0, runts = 0;

  always #2 clk_cpu = ~clk_cpu;
  always #5 clk_pci = ~clk_pci;

  clkstop_ctrl u_clkstop_ctrl (
    .clk_cpu(clk_cpu), .clk_pci(clk_pci), .rst_n(rst_n), .pwr_good_n(pwr_good_n),
    .strap_fs(strap_fs), .mult_sel(mult_sel), .pd_n(pd_n), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .cpu_en(cpu_en), .pci_en(pci_en), .cpu_free(cpu_free),
    .relock_len(relock_len), .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out),
    .cpu_gate(cpu_gate), .pci_gate(pci_gate), .strap_rb(strap_rb));

  // R11 monitor: gated high pulses must be full half periods
  realtime t_c, t_p;
  always @(posedge cpu_clk_out[0]) t_c = $realtime;
  always @(negedge cpu_clk_out[0]) if ($realtime - t_c < 1.99) runts++;
  always @(posedge pci_clk_out[1]) t_p = $realtime;
  always @(negedge pci_clk_out[1]) if ($realtime - t_p < 4.99) runts++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_cpu);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 0; pwr_good_n = 1; mult_sel = 1; pd_n = 1; cpu_stop_n = 1; pci_stop_n = 1;
    strap_fs = 5'b10110; cpu_en = '1; pci_en = '1; cpu_free = '0; relock_len = 16'd5;
    #20;
    check("R10 cpu_gate", cpu_gate, 0);
    check("R10 pci_gate", pci_gate, 0);
    check("R10 clocks", {cpu_clk_out, pci_clk_out}, 0);
    check("R10 strap_rb", strap_rb, 6'b000001);
    @(posedge clk_cpu); #1 rst_n = 1;
  endtask

  task automatic t_straps_pending;
    step(30);
    check("R8 cpu_gate", cpu_gate, 0);
    check("R8 pci_gate", pci_gate, 0);
  endtask

  task automatic t_strap_capture;
    pwr_good_n = 0; step(8);
    check("R7 capture", strap_rb, {5'b10110, 1'b1});
    strap_fs = 5'b01001; pwr_good_n = 1; step(5); pwr_good_n = 0; mult_sel = 0; step(8);
    check("R7 hold", strap_rb, {5'b10110, 1'b0});
    step(20);
    check("R8 cpu running", cpu_gate, 3'b111);
    check("R8 pci running", pci_gate, 7'h7f);
  endtask

  task automatic t_cpu_stop;
    cpu_free = 3'b010; cpu_stop_n = 0; step(20);
    check("R3 R4 cpu stop", cpu_gate, 3'b010);
    check("R3 pci untouched", pci_gate, 7'h7f);
    cpu_stop_n = 1; step(20);
    check("R3 release", cpu_gate, 3'b111);
  endtask

  task automatic t_pci_stop;
    pci_stop_n = 0; step(20);
    check("R5 pci stop", pci_gate, 7'b0000001);
    check("R5 cpu untouched", cpu_gate, 3'b111);
    pci_stop_n = 1; step(20);
    check("R5 release", pci_gate, 7'h7f);
  endtask

  task automatic t_enables;
    cpu_en = 3'b101; pci_en = 7'b1111110; step(20);
    check("R6 cpu en", cpu_gate, 3'b101);
    check("R6 pci en", pci_gate, 7'b1111110);
    cpu_free = 3'b010; cpu_stop_n = 0; step(20);
    check("R6 en over free", cpu_gate, 3'b000);
    cpu_stop_n = 1; cpu_en = '1; pci_en = '1; cpu_free = '0; step(20);
    check("R6 restore", {cpu_gate, pci_gate}, 10'h3ff);
  endtask

  task automatic t_pd_glitch;
    pd_n = 0; step(1); pd_n = 1; step(20);
    check("R1 single low sample", {cpu_gate, pci_gate}, 10'h3ff);
  endtask

  task automatic t_pd_cycle(int len);
    relock_len = 16'(len);
    pd_n = 0; step(20);
    check("R2 gates off", {cpu_gate, pci_gate}, 0);
    for (int k = 0; k < 6; k++) begin
      #0.7;
      check("R2 outputs low", {cpu_clk_out, pci_clk_out}, 0);
    end
    @(posedge clk_cpu); #1 pd_n = 1;
    repeat (len + 3) @(posedge clk_cpu);
    #3;
    check("R9 still off", cpu_gate, 3'b000);
    @(posedge clk_cpu); #3;
    check("R9 released", cpu_gate, 3'b111);
    step(20);
    check("R9 pci released", pci_gate, 7'h7f);
  endtask

  initial begin
    t_reset();
    t_straps_pending();
    t_strap_capture();
    t_cpu_stop();
    t_pci_stop();
    t_enables();
    t_pd_glitch();
    t_pd_cycle(5);
    t_pd_cycle(0);
    check("R11 no runt pulses", runts, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule